// File: doc/BRIEF.md
# Dual-width accumulator ALU

This block is the arithmetic and logic stage of a small accumulator processor whose data path runs at either byte or word width. Each cycle it receives an operation code, the accumulator operand, the memory operand, the current flag bits and a width select, and one clock later it presents the result, the new flag bits, a mask of the flags the operation wrote, and a strobe saying whether the result is meant to be written back.

The width select chooses between the low half of the operands (narrow, 8 bits at the default width) and the full word (wide, 16 bits). Sign, signed overflow and shifted-out bits are all taken from the top of the chosen width. Flags that an operation does not write are passed through from the flag input, so the flag output can be stored directly into the status register. Decimal arithmetic, operand fetch and writeback sit outside this block.

Top module: `dwacc_alu`

## Requirements
- R1: With `wide_i` = 0 only bits 7:0 of `a_i` and `b_i` are used and `res_o` bits 15:8 are zero; with `wide_i` = 1 all 16 bits are used. Flag vectors are ordered {n, v, z, c} at bits 3..0, where n is the top bit of the selected width and z means the width-masked value is zero.
- R2: Operation code 0 (add) returns A + B + c modulo the width, carry out into c, signed overflow into v, and writes n, v, z, c with write strobe 1.
- R3: Operation code 1 (subtract) returns A + ~B + c, so c = 1 afterwards means no borrow; v is set when the effective addends share a sign that the result does not; writes n, v, z, c with strobe 1.
- R4: Codes 2 (increment) and 3 (decrement) add or subtract one with wraparound, write only n and z, and keep v and c from the flag input.
- R5: Codes 4, 5, 6 return A AND B, A OR B and A XOR B respectively, writing only n and z.
- R6: Code 7 (bit test) gives strobe 0, takes n from the top bit of B, v from the bit just below it (bit 6 narrow, bit 14 wide), sets z when A AND B is zero, and leaves c unchanged.
- R7: Code 8 (compare) gives strobe 0, sets c when A >= B unsigned, n from the top bit of A - B, z when they are equal, and leaves v unchanged.
- R8: Code 9 shifts left and code 10 shifts right, both moving a zero in and the bit pushed out into c; the right shift always clears n. Both write n, z, c.
- R9: Codes 11 (rotate left) and 12 (rotate right) move the incoming c into the vacated end and the bit pushed out into c, writing n, z, c.
- R10: Codes 13 (test-and-set) and 14 (test-and-reset) return B OR A and B AND NOT A, set z from A AND B taken before modification, and write only z, with strobe 1.
- R11: `upd_o` marks the flags written, bit order as in R1; every flag not marked equals the same flag of `flags_i`.
- R12: Outputs appear one clock after the inputs; reset drives all outputs to zero; code 15 is a no-operation with strobe 0, mask 0 and flags passed through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| wide_i | input | 1 | 1 = full-word operation, 0 = low-half operation |
| a_i | input | 16 | Accumulator operand (also the bit mask for test-and-set/reset) |
| b_i | input | 16 | Memory operand |
| flags_i | input | 4 | Current flags {n, v, z, c}; c is the carry in |
| res_o | output | 16 | Result |
| flags_o | output | 4 | Next flags {n, v, z, c} |
| upd_o | output | 4 | Flags written by the operation |
| we_o | output | 1 | Result is to be written back |

## Verification
The hardest situation to reach is a narrow operation whose outcome would differ if the upper operand byte leaked in: a carry out of bit 7, an overflow judged at bit 7, or a shifted bit crossing into bit 8. The sweep therefore fills the upper byte with a fixed non-zero pattern on every narrow vector, so any leak changes the result or a flag, and it crosses grid operand values, both carry inputs and varying pass-through flags with every operation at both widths.

// File: rtl/dwacc_alu_pkg.sv
`timescale 1ns/1ps
package dwacc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_INC  = 4'd2,
        OP_DEC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_BIT  = 4'd7,
        OP_CMP  = 4'd8,
        OP_SHL  = 4'd9,
        OP_SHR  = 4'd10,
        OP_ROL  = 4'd11,
        OP_ROR  = 4'd12,
        OP_TSET = 4'd13,
        OP_TCLR = 4'd14,
        OP_NOP  = 4'd15
    } op_e;

    // flag vector positions
    localparam int unsigned FN = 3;
    localparam int unsigned FV = 2;
    localparam int unsigned FZ = 1;
    localparam int unsigned FC = 0;

    localparam logic [3:0] UPD_NVZC = 4'b1111;
    localparam logic [3:0] UPD_NZC  = 4'b1011;
    localparam logic [3:0] UPD_NZ   = 4'b1010;
    localparam logic [3:0] UPD_NVZ  = 4'b1110;
    localparam logic [3:0] UPD_Z    = 4'b0010;

endpackage

// File: rtl/dwacc_alu_adder.sv
`timescale 1ns/1ps
module dwacc_alu_adder #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    input  logic         wide_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    localparam int unsigned H = W / 2;

    logic [W:0] full_sum;
    logic [H:0] half_sum;

    always_comb begin
        full_sum = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
        half_sum = {1'b0, x_i[H-1:0]} + {1'b0, y_i[H-1:0]} + {{H{1'b0}}, cin_i};
        if (wide_i) begin
            sum_o  = full_sum[W-1:0];
            cout_o = full_sum[W];
            ovf_o  = (x_i[W-1] == y_i[W-1]) && (full_sum[W-1] != x_i[W-1]);
        end else begin
            sum_o  = {{(W-H){1'b0}}, half_sum[H-1:0]};
            cout_o = half_sum[H];
            ovf_o  = (x_i[H-1] == y_i[H-1]) && (half_sum[H-1] != x_i[H-1]);
        end
    end
endmodule

// File: rtl/dwacc_alu_shifter.sv
`timescale 1ns/1ps
module dwacc_alu_shifter #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic         cin_i,
    input  logic         wide_i,
    input  logic         left_i,
    input  logic         rot_i,
    output logic [W-1:0] y_o,
    output logic         cout_o
);
    localparam int unsigned H = W / 2;

    logic fill;

    always_comb begin
        fill = rot_i & cin_i;
        if (left_i) begin
            if (wide_i) begin
                y_o    = {x_i[W-2:0], fill};
                cout_o = x_i[W-1];
            end else begin
                y_o    = {{(W-H){1'b0}}, x_i[H-2:0], fill};
                cout_o = x_i[H-1];
            end
        end else begin
            cout_o = x_i[0];
            if (wide_i) begin
                y_o = {fill, x_i[W-1:1]};
            end else begin
                y_o = {{(W-H){1'b0}}, fill, x_i[H-1:1]};
            end
        end
    end
endmodule

// File: rtl/dwacc_alu_logic.sv
`timescale 1ns/1ps
module dwacc_alu_logic #(
    parameter int unsigned W = 16
) (
    input  dwacc_alu_pkg::op_e op_i,
    input  logic [W-1:0]       a_i,
    input  logic [W-1:0]       b_i,
    output logic [W-1:0]       y_o
);
    import dwacc_alu_pkg::*;

    always_comb begin
        unique case (op_i)
            OP_AND:  y_o = a_i & b_i;
            OP_OR:   y_o = a_i | b_i;
            OP_XOR:  y_o = a_i ^ b_i;
            OP_TSET: y_o = b_i | a_i;
            OP_TCLR: y_o = b_i & ~a_i;
            default: y_o = a_i;
        endcase
    end
endmodule

// File: rtl/dwacc_alu.sv
`timescale 1ns/1ps
module dwacc_alu #(
    parameter int unsigned W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [3:0]   op_i,
    input  logic         wide_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   flags_i,
    output logic [W-1:0] res_o,
    output logic [3:0]   flags_o,
    output logic [3:0]   upd_o,
    output logic         we_o
);
    import dwacc_alu_pkg::*;

    localparam int unsigned H = W / 2;

    typedef struct packed {
        logic [W-1:0] res;
        logic [3:0]   flags;
        logic [3:0]   upd;
        logic         we;
    } alu_out_t;

    alu_out_t     out_d, out_q;
    op_e          op;
    logic [W-1:0] wmask;
    logic [W-1:0] add_y;
    logic         add_c;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic         add_ovf;
    logic [W-1:0] sh_y;
    logic         sh_cout;
    logic [W-1:0] lg_y;
    logic [W-1:0] a_m;
    logic [W-1:0] b_m;

    assign op    = op_e'(op_i);
    assign wmask = wide_i ? {W{1'b1}} : {{(W-H){1'b0}}, {H{1'b1}}};
    assign a_m   = a_i & wmask;
    assign b_m   = b_i & wmask;

    // second addend and carry for the shared adder
    always_comb begin
        add_y = b_m;
        add_c = flags_i[FC];
        unique case (op)
            OP_SUB:  add_y = ~b_m;
            OP_CMP:  begin add_y = ~b_m;      add_c = 1'b1; end
            OP_INC:  begin add_y = '0;        add_c = 1'b1; end
            OP_DEC:  begin add_y = {W{1'b1}}; add_c = 1'b0; end
            default: ;
        endcase
    end

    dwacc_alu_adder #(.W(W)) adder_i (
        .x_i    (a_m),
        .y_i    (add_y),
        .cin_i  (add_c),
        .wide_i (wide_i),
        .sum_o  (add_sum),
        .cout_o (add_cout),
        .ovf_o  (add_ovf)
    );

    dwacc_alu_shifter #(.W(W)) shifter_i (
        .x_i    (a_m),
        .cin_i  (flags_i[FC]),
        .wide_i (wide_i),
        .left_i ((op == OP_SHL) || (op == OP_ROL)),
        .rot_i  ((op == OP_ROL) || (op == OP_ROR)),
        .y_o    (sh_y),
        .cout_o (sh_cout)
    );

    dwacc_alu_logic #(.W(W)) logic_i (
        .op_i (op),
        .a_i  (a_m),
        .b_i  (b_m),
        .y_o  (lg_y)
    );

    always_comb begin
        logic [W-1:0] r;
        logic [3:0]   f;
        logic         top;
        r   = a_m;
        f   = flags_i;
        out_d.upd = '0;
        out_d.we  = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                r = add_sum; f[FC] = add_cout; f[FV] = add_ovf;
                out_d.upd = UPD_NVZC; out_d.we = 1'b1;
            end
            OP_INC, OP_DEC: begin
                r = add_sum; out_d.upd = UPD_NZ; out_d.we = 1'b1;
            end
            OP_CMP: begin
                r = add_sum; f[FC] = add_cout; out_d.upd = UPD_NZC;
            end
            OP_AND, OP_OR, OP_XOR: begin
                r = lg_y; out_d.upd = UPD_NZ; out_d.we = 1'b1;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                r = sh_y; f[FC] = sh_cout; out_d.upd = UPD_NZC; out_d.we = 1'b1;
            end
            OP_TSET, OP_TCLR: begin
                r = lg_y; out_d.upd = UPD_Z; out_d.we = 1'b1;
            end
            OP_BIT: begin
                out_d.upd = UPD_NVZ;
            end
            default: ;
        endcase
        r   = r & wmask;
        top = wide_i ? r[W-1] : r[H-1];
        f[FN] = (op == OP_SHR) ? 1'b0 : top;
        f[FZ] = (r == '0);
        if (op == OP_BIT) begin
            f[FN] = wide_i ? b_i[W-1] : b_i[H-1];
            f[FV] = wide_i ? b_i[W-2] : b_i[H-2];
        end
        if ((op == OP_BIT) || (op == OP_TSET) || (op == OP_TCLR)) begin
            f[FZ] = ((a_m & b_m) == '0);
        end
        // compare and bit test deliver no result
        out_d.res   = out_d.we ? r : '0;
        out_d.flags = (f & out_d.upd) | (flags_i & ~out_d.upd);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign res_o   = out_q.res;
    assign flags_o = out_q.flags;
    assign upd_o   = out_q.upd;
    assign we_o    = out_q.we;

endmodule

// File: rtl/dwacc_alu_chk.sv
`timescale 1ns/1ps
module dwacc_alu_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic [3:0]   op_i,
    input logic         wide_i,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [3:0]   flags_i,
    input logic [W-1:0] res_o,
    input logic [3:0]   flags_o,
    input logic [3:0]   upd_o,
    input logic         we_o
);
    import dwacc_alu_pkg::*;

    localparam int unsigned H = W / 2;

    logic armed_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) armed_q <= 1'b0;
        else         armed_q <= 1'b1;
    end

    a_r1_narrow_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && !$past(wide_i)) |-> (res_o[W-1:H] == '0));

    a_r4_incdec_keep_vc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC))
        |-> (flags_o[FC] == $past(flags_i[FC]) && flags_o[FV] == $past(flags_i[FV])));

    a_r6_bit_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && $past(op_i) == OP_BIT)
        |-> (!we_o && flags_o[FC] == $past(flags_i[FC])));

    a_r7_cmp_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && $past(op_i) == OP_CMP)
        |-> (flags_o[FC] == ($past(wide_i) ? ($past(a_i) >= $past(b_i))
                                           : ($past(a_i[H-1:0]) >= $past(b_i[H-1:0])))));

    a_r8_shr_clears_n: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && $past(op_i) == OP_SHR) |-> !flags_o[FN]);

    a_r10_tbits_z_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && ($past(op_i) == OP_TSET || $past(op_i) == OP_TCLR))
        |-> (upd_o == UPD_Z && we_o));

    a_r11_unmasked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q |-> (((flags_o ^ $past(flags_i)) & ~upd_o) == 4'b0000));

    a_r12_nop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && $past(op_i) == OP_NOP) |-> (upd_o == 4'b0000 && !we_o));

endmodule

bind dwacc_alu dwacc_alu_chk #(.W(W)) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op_i),
    .wide_i  (wide_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .flags_i (flags_i),
    .res_o   (res_o),
    .flags_o (flags_o),
    .upd_o   (upd_o),
    .we_o    (we_o)
);

// File: tb/dwacc_alu_tb_top.sv
`timescale 1ns/1ps
module dwacc_alu_tb_top;

    localparam int W = 16;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic [3:0]   op_i = '0;
    logic         wide_i = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic [3:0]   flags_i = '0;
    logic [W-1:0] res_o;
    logic [3:0]   flags_o;
    logic [3:0]   upd_o;
    logic         we_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk_i = ~clk_i;

    dwacc_alu #(.W(W)) dut_i (
        .clk_i, .rst_ni, .op_i, .wide_i, .a_i, .b_i, .flags_i,
        .res_o, .flags_o, .upd_o, .we_o
    );

    function automatic string req_of(int op);
        case (op)
            0: return "R2";
            1: return "R3";
            2, 3: return "R4";
            4, 5, 6: return "R5";
            7: return "R6";
            8: return "R7";
            9, 10: return "R8";
            11, 12: return "R9";
            13, 14: return "R10";
            default: return "R12";
        endcase
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference model: integer arithmetic on the selected width
    task automatic model(input int op, input int wide, input int a_full, input int b_full,
                         input int fin, output int r, output int fo, output int upd, output int we);
        int md, msb, a, b, c, s, sa, sb, ss, n, v, z, cy, am;
        md  = wide ? 65536 : 256;
        msb = md / 2;
        a   = a_full % md;
        b   = b_full % md;
        c   = fin & 1;
        n = 0; v = 0; z = 0; cy = 0; r = 0; upd = 0; we = 0;
        sa = (a >= msb) ? a - md : a;
        sb = (b >= msb) ? b - md : b;
        am = a & b;
        case (op)
            0: begin s = a + b + c; r = s % md; cy = (s >= md); ss = sa + sb + c;
                     v = (ss >= msb || ss < -msb); upd = 4'hF; we = 1; end
            1: begin s = a + (md - 1 - b) + c; r = s % md; cy = (s >= md); ss = sa - sb - 1 + c;
                     v = (ss >= msb || ss < -msb); upd = 4'hF; we = 1; end
            2: begin r = (a + 1) % md; upd = 4'hA; we = 1; end
            3: begin r = (a + md - 1) % md; upd = 4'hA; we = 1; end
            4: begin r = a & b; upd = 4'hA; we = 1; end
            5: begin r = a | b; upd = 4'hA; we = 1; end
            6: begin r = a ^ b; upd = 4'hA; we = 1; end
            7: begin upd = 4'hE; end
            8: begin upd = 4'hB; cy = (a >= b); end
            9: begin r = (a * 2) % md; cy = (a >= msb); upd = 4'hB; we = 1; end
            10: begin r = a / 2; cy = a % 2; upd = 4'hB; we = 1; end
            11: begin r = (a * 2) % md + c; cy = (a >= msb); upd = 4'hB; we = 1; end
            12: begin r = a / 2 + c * msb; cy = a % 2; upd = 4'hB; we = 1; end
            13: begin r = b | a; upd = 4'h2; we = 1; end
            14: begin r = b & ~a & (md - 1); upd = 4'h2; we = 1; end
            default: ;
        endcase
        n = (r >= msb) && (op != 10);
        z = (r == 0);
        if (op == 8) begin
            n = (((a - b + md) % md) >= msb);
            z = (a == b);
        end
        if (op == 7) begin
            n = (b >= msb);
            v = ((b / (msb / 2)) % 2);
            z = (am == 0);
        end
        if (op == 13 || op == 14) z = (am == 0);
        fo = ((n * 8 + v * 4 + z * 2 + cy) & upd) | (fin & ~upd & 15);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int er, ef, eu, ew;
        // R12: reset state
        repeat (3) @(negedge clk_i);
        check("R12", "reset res", int'(res_o), 0);
        check("R12", "reset flags", int'(flags_o), 0);
        check("R12", "reset upd", int'(upd_o), 0);
        check("R12", "reset we", int'(we_o), 0);
        rst_ni = 1'b1;
        @(negedge clk_i);

        for (int wd = 0; wd < 2; wd++) begin
            for (int op = 0; op < 16; op++) begin
                for (int ai = 0; ai < 18; ai++) begin
                    for (int bi = 0; bi < 18; bi++) begin
                        for (int c = 0; c < 2; c++) begin
                            int av, bv, fi;
                            if (wd == 1) begin
                                av = ai * 3855;
                                bv = (bi * 3855) ^ ((bi % 3) * 257);
                            end else begin
                                // upper byte holds junk that R1 says is ignored
                                av = 32'hA500 | ((ai * 15) & 255);
                                bv = 32'h5A00 | ((bi * 15 + bi / 4) & 255);
                            end
                            fi = ((ai % 2) << 3) | ((bi % 2) << 2) | (((ai + bi) % 2) << 1) | c;
                            op_i    = 4'(op);
                            wide_i  = 1'(wd);
                            a_i     = W'(av);
                            b_i     = W'(bv);
                            flags_i = 4'(fi);
                            model(op, wd, av, bv, fi, er, ef, eu, ew);
                            @(posedge clk_i);
                            @(negedge clk_i);
                            check(req_of(op), "result", int'(res_o), ew ? er : 0);
                            check(req_of(op), "flags",  int'(flags_o), ef);
                            check("R11", "update mask", int'(upd_o), eu);
                            check(req_of(op), "write strobe", int'(we_o), ew);
                            if (wd == 0) check("R1", "narrow upper byte", int'(res_o[15:8]), 0);
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule